// File: doc/BRIEF.md
# Register Alias Rename Table

This block is the register-renaming step of an out-of-order core front end. Each cycle up to four micro-ops arrive in program order, oldest in lane 0. Every micro-op names two source architectural registers and one destination architectural register. Every micro-op also carries the reorder-buffer index that the allocator gave it, and that index is its physical tag. For each source the block answers one of two things. Either the value comes from the committed architectural file, or it comes from a named reorder-buffer entry. The block then records each destination's tag as the newest producer of that register.

The table keeps one entry per architectural register: a valid flag and a tag. A clear flag means that no producer is in flight, so readers go to the architectural file. A source in lane k first looks at the older lanes of the same group that write the same register, and the youngest of those wins. Only when none of them matches does it fall back to the table. A retiring micro-op clears its register's entry, but only while that entry still names the retiring tag. A flush empties the whole table in one cycle.

Source answers are combinational from the current group and table. Table updates take effect at the next rising clock edge.

Top module: `rename_alias`

## Requirements
- R1: After reset every table entry is clear, so every source of a valid lane reports `inflight`=0 and tag 0 until a rename writes its register.
- R2: A valid lane with destination A and tag T, in a cycle without flush and with no younger lane of the group also writing A, makes later sources of A report `inflight`=1 and tag T.
- R3: A source whose register has no in-flight producer, neither in the table nor in an older lane of its group, reports `inflight`=0 and tag 0.
- R4: A source of lane k whose register is written by one or more older valid lanes j<k of the same group reports `inflight`=1 with the tag of the youngest such lane, whatever the table holds.
- R5: When several valid lanes of one group write the same register, the table keeps the tag of the highest-numbered one.
- R6: Retirement of tag T for register A clears A's entry only if the entry is valid and holds T. Otherwise the entry is unchanged.
- R7: If a retirement and a rename of the same register fall in the same cycle, the rename's tag is kept and the entry stays valid.
- R8: Flush clears every entry at the next edge and takes priority over renames and retirement in the same cycle. The next cycle's sources with no older in-group producer report `inflight`=0.
- R9: A lane with `grp_valid` low writes nothing and bypasses to no younger lane. Both of its source outputs read `inflight`=0, tag 0.
- R10: With r1 mapped to tag 19 and r2 to tag 23, the op r0=r1+r0 with tag 37 gives sources (19, architectural). The op r0=r2-r0 with tag 38 that follows gives sources (23, 37), both when the two ops share a group and when they are in successive cycles.

Lane k of every packed lane port is element [k]. Register numbers are binary, and tags are reorder-buffer indices 0..39.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Clear all mappings |
| grp_valid | input | LANES | Lane holds a micro-op |
| grp_dst | input | LANES x AW | Destination register per lane |
| grp_src_a | input | LANES x AW | First source register per lane |
| grp_src_b | input | LANES x AW | Second source register per lane |
| grp_tag | input | LANES x TW | Allocated reorder-buffer tag per lane |
| ret_valid | input | 1 | A micro-op retires this cycle |
| ret_arch | input | AW | Destination register of the retiring micro-op |
| ret_tag | input | TW | Tag of the retiring micro-op |
| src_a_inflight | output | LANES | First source comes from the reorder buffer |
| src_a_tag | output | LANES x TW | Tag for first source |
| src_b_inflight | output | LANES | Second source comes from the reorder buffer |
| src_b_tag | output | LANES x TW | Tag for second source |

## Verification
Directed groups separate the three places an answer can come from. These are an empty table, a table hit, and an older lane of the same group, with a stale table entry present so that a wrong priority shows up. Groups where two lanes write one register check that the youngest writer wins both for the bypass and for the stored entry. Groups with a gap of invalid lanes show that idle lanes neither bypass nor write. Retire patterns use a matching tag, a stale tag, and a same-cycle rename of the retiring register, which separates a clear from a keep from an override. A long pseudo-random sweep mixes all of these with flushes, and a reference model computed from the requirements checks every output every cycle.

// File: rtl/rename_alias_pkg.sv
package rename_alias_pkg;

  // Where a resolved source value comes from.
  typedef enum logic [1:0] {
    SRC_ARCH   = 2'd0,
    SRC_TABLE  = 2'd1,
    SRC_BYPASS = 2'd2
  } src_origin_e;

  localparam int DEF_LANES     = 4;
  localparam int DEF_ARCH_REGS = 8;
  localparam int DEF_ROB_DEPTH = 40;

endpackage

// File: rtl/alias_store.sv
module alias_store #(
  parameter int ARCH_REGS = 8,
  parameter int TW        = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic [ARCH_REGS-1:0]          wr_en,
  input  logic [ARCH_REGS-1:0][TW-1:0]  wr_tag,
  input  logic [ARCH_REGS-1:0]          clr_en,
  output logic [ARCH_REGS-1:0]          map_valid,
  output logic [ARCH_REGS-1:0][TW-1:0]  map_tag
);

  for (genvar a = 0; a < ARCH_REGS; a++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_valid[a] <= 1'b0;
        map_tag[a]   <= '0;
      end else if (flush) begin
        map_valid[a] <= 1'b0;
      end else if (wr_en[a]) begin
        map_valid[a] <= 1'b1;
        map_tag[a]   <= wr_tag[a];
      end else if (clr_en[a]) begin
        map_valid[a] <= 1'b0;
      end
    end

    // R7: a write requested by the merge stage lands in the entry
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !flush && wr_en[a] |=> map_valid[a] && map_tag[a] == $past(wr_tag[a]));
  end

endmodule

// File: rtl/dest_merge.sv
module dest_merge #(
  parameter int LANES     = 4,
  parameter int ARCH_REGS = 8,
  parameter int AW        = 3,
  parameter int TW        = 6
) (
  input  logic [LANES-1:0]              lane_vld,
  input  logic [LANES-1:0][AW-1:0]      lane_dst,
  input  logic [LANES-1:0][TW-1:0]      lane_tag,
  input  logic                          ret_valid,
  input  logic [AW-1:0]                 ret_arch,
  input  logic [TW-1:0]                 ret_tag,
  input  logic [ARCH_REGS-1:0]          map_valid,
  input  logic [ARCH_REGS-1:0][TW-1:0]  map_tag,
  output logic [ARCH_REGS-1:0]          wr_en,
  output logic [ARCH_REGS-1:0][TW-1:0]  wr_tag,
  output logic [ARCH_REGS-1:0]          clr_en,
  output logic                          ret_hit
);

  // Youngest valid lane writing each register wins (later lanes overwrite).
  always_comb begin
    wr_en  = '0;
    wr_tag = '0;
    for (int a = 0; a < ARCH_REGS; a++) begin
      for (int j = 0; j < LANES; j++) begin
        if (lane_vld[j] && lane_dst[j] == AW'(a)) begin
          wr_en[a]  = 1'b1;
          wr_tag[a] = lane_tag[j];
        end
      end
    end
  end

  // Retire clears only while the entry still names the retiring tag,
  // and never over a same-cycle rename of that register.
  always_comb begin
    ret_hit = 1'b0;
    clr_en  = '0;
    for (int a = 0; a < ARCH_REGS; a++) begin
      if (ret_valid && ret_arch == AW'(a) && map_valid[a] && map_tag[a] == ret_tag) begin
        ret_hit = 1'b1;
        clr_en[a] = !wr_en[a];
      end
    end
  end

endmodule

// File: rtl/src_resolve.sv
module src_resolve
  import rename_alias_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int LANE      = 0,
  parameter int ARCH_REGS = 8,
  parameter int AW        = 3,
  parameter int TW        = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LANES-1:0]              lane_vld,
  input  logic [LANES-1:0][AW-1:0]      lane_dst,
  input  logic [LANES-1:0][TW-1:0]      lane_tag,
  input  logic [AW-1:0]                 src_arch,
  input  logic [ARCH_REGS-1:0]          map_valid,
  input  logic [ARCH_REGS-1:0][TW-1:0]  map_tag,
  output logic                          inflight,
  output logic [TW-1:0]                 tag
);

  logic          tbl_vld;
  logic [TW-1:0] tbl_tag;
  logic          byp_hit;
  logic [TW-1:0] byp_tag;
  src_origin_e   origin;

  always_comb begin
    tbl_vld = 1'b0;
    tbl_tag = '0;
    for (int a = 0; a < ARCH_REGS; a++) begin
      if (src_arch == AW'(a)) begin
        tbl_vld = map_valid[a];
        tbl_tag = map_tag[a];
      end
    end
  end

  // Older lanes only; the last match is the youngest older producer.
  always_comb begin
    byp_hit = 1'b0;
    byp_tag = '0;
    for (int j = 0; j < LANES; j++) begin
      if (j < LANE && lane_vld[j] && lane_dst[j] == src_arch) begin
        byp_hit = 1'b1;
        byp_tag = lane_tag[j];
      end
    end
  end

  always_comb begin
    if (!lane_vld[LANE])  origin = SRC_ARCH;
    else if (byp_hit)     origin = SRC_BYPASS;
    else if (tbl_vld)     origin = SRC_TABLE;
    else                  origin = SRC_ARCH;
  end

  assign inflight = (origin != SRC_ARCH);
  assign tag      = (origin == SRC_BYPASS) ? byp_tag :
                    (origin == SRC_TABLE)  ? tbl_tag : '0;

  // R9: an idle lane reports nothing
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_vld[LANE] |-> !inflight && tag == '0);

  if (LANE > 0) begin : g_chk
    // R4: the immediately older lane writing this register always wins
    p_bypass_prev_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lane_vld[LANE] && lane_vld[LANE-1] && lane_dst[LANE-1] == src_arch
      |-> inflight && tag == lane_tag[LANE-1]);
  end

endmodule

// File: rtl/rename_alias.sv
module rename_alias
  import rename_alias_pkg::*;
#(
  parameter int LANES     = DEF_LANES,
  parameter int ARCH_REGS = DEF_ARCH_REGS,
  parameter int ROB_DEPTH = DEF_ROB_DEPTH,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int TW = $clog2(ROB_DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [LANES-1:0]          grp_valid,
  input  logic [LANES-1:0][AW-1:0]  grp_dst,
  input  logic [LANES-1:0][AW-1:0]  grp_src_a,
  input  logic [LANES-1:0][AW-1:0]  grp_src_b,
  input  logic [LANES-1:0][TW-1:0]  grp_tag,
  input  logic                      ret_valid,
  input  logic [AW-1:0]             ret_arch,
  input  logic [TW-1:0]             ret_tag,
  output logic [LANES-1:0]          src_a_inflight,
  output logic [LANES-1:0][TW-1:0]  src_a_tag,
  output logic [LANES-1:0]          src_b_inflight,
  output logic [LANES-1:0][TW-1:0]  src_b_tag
);

  logic [ARCH_REGS-1:0]          map_valid;
  logic [ARCH_REGS-1:0][TW-1:0]  map_tag;
  logic [ARCH_REGS-1:0]          wr_en;
  logic [ARCH_REGS-1:0][TW-1:0]  wr_tag;
  logic [ARCH_REGS-1:0]          clr_en;
  logic                          ret_hit;

  dest_merge #(.LANES(LANES), .ARCH_REGS(ARCH_REGS), .AW(AW), .TW(TW)) u_merge (
    .lane_vld (grp_valid),
    .lane_dst (grp_dst),
    .lane_tag (grp_tag),
    .ret_valid(ret_valid),
    .ret_arch (ret_arch),
    .ret_tag  (ret_tag),
    .map_valid(map_valid),
    .map_tag  (map_tag),
    .wr_en    (wr_en),
    .wr_tag   (wr_tag),
    .clr_en   (clr_en),
    .ret_hit  (ret_hit)
  );

  alias_store #(.ARCH_REGS(ARCH_REGS), .TW(TW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (wr_en),
    .wr_tag   (wr_tag),
    .clr_en   (clr_en),
    .map_valid(map_valid),
    .map_tag  (map_tag)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    src_resolve #(.LANES(LANES), .LANE(k), .ARCH_REGS(ARCH_REGS), .AW(AW), .TW(TW)) u_a (
      .clk(clk), .rst_n(rst_n),
      .lane_vld(grp_valid), .lane_dst(grp_dst), .lane_tag(grp_tag),
      .src_arch(grp_src_a[k]), .map_valid(map_valid), .map_tag(map_tag),
      .inflight(src_a_inflight[k]), .tag(src_a_tag[k])
    );
    src_resolve #(.LANES(LANES), .LANE(k), .ARCH_REGS(ARCH_REGS), .AW(AW), .TW(TW)) u_b (
      .clk(clk), .rst_n(rst_n),
      .lane_vld(grp_valid), .lane_dst(grp_dst), .lane_tag(grp_tag),
      .src_arch(grp_src_b[k]), .map_valid(map_valid), .map_tag(map_tag),
      .inflight(src_b_inflight[k]), .tag(src_b_tag[k])
    );
  end

  // R6: a matching retire with no competing rename empties the entry
  p_retire_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !flush && ret_hit && !wr_en[ret_arch]
    |=> !map_valid[$past(ret_arch)]);

  // R6: a stale retire leaves the entry as it was
  p_retire_stale_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !flush && map_valid[ret_arch] && map_tag[ret_arch] != ret_tag
    && !wr_en[ret_arch]
    |=> map_valid[$past(ret_arch)] && map_tag[$past(ret_arch)] == $past(map_tag[ret_arch]));

  // R8: after a flush, lane 0 (no older producer) reads the architectural file
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 grp_valid[0] |-> !src_a_inflight[0] && !src_b_inflight[0]);

endmodule

// File: tb/rename_alias_tb_top.sv
module rename_alias_tb_top;
  localparam int CLK_P = 10;
  localparam int L  = 4;
  localparam int NR = 8;
  localparam int AW = 3;
  localparam int TW = 6;
  localparam int ROB = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic [L-1:0] grp_valid = '0;
  logic [L-1:0][AW-1:0] grp_dst = '0, grp_src_a = '0, grp_src_b = '0;
  logic [L-1:0][TW-1:0] grp_tag = '0;
  logic ret_valid = 1'b0;
  logic [AW-1:0] ret_arch = '0;
  logic [TW-1:0] ret_tag = '0;
  logic [L-1:0] src_a_inflight, src_b_inflight;
  logic [L-1:0][TW-1:0] src_a_tag, src_b_tag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model of the table
  bit       mv [NR];
  int       mt [NR];

  always #(CLK_P/2) clk = ~clk;

  rename_alias dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .grp_valid(grp_valid), .grp_dst(grp_dst), .grp_src_a(grp_src_a),
    .grp_src_b(grp_src_b), .grp_tag(grp_tag),
    .ret_valid(ret_valid), .ret_arch(ret_arch), .ret_tag(ret_tag),
    .src_a_inflight(src_a_inflight), .src_a_tag(src_a_tag),
    .src_b_inflight(src_b_inflight), .src_b_tag(src_b_tag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected answer for a source: table first, then every older writer
  // in order so the last one (youngest) stands
  function automatic int expect_src(input int k, input int a, output bit inf);
    int t;
    inf = 1'b0; t = 0;
    if (grp_valid[k]) begin
      inf = mv[a]; t = mv[a] ? mt[a] : 0;
      for (int j = 0; j < k; j++)
        if (grp_valid[j] && int'(grp_dst[j]) == a) begin inf = 1'b1; t = int'(grp_tag[j]); end
    end
    return t;
  endfunction

  task automatic check_all(input string req);
    bit ei; int et;
    for (int k = 0; k < L; k++) begin
      et = expect_src(k, int'(grp_src_a[k]), ei);
      chk({req, " srcA inflight"}, int'(src_a_inflight[k]), int'(ei));
      chk({req, " srcA tag"}, int'(src_a_tag[k]), et);
      et = expect_src(k, int'(grp_src_b[k]), ei);
      chk({req, " srcB inflight"}, int'(src_b_inflight[k]), int'(ei));
      chk({req, " srcB tag"}, int'(src_b_tag[k]), et);
    end
  endtask

  // clock edge, then model update from the inputs held across it
  task automatic tick();
    @(posedge clk);
    if (flush) begin
      for (int a = 0; a < NR; a++) mv[a] = 1'b0;
    end else begin
      if (ret_valid && mv[ret_arch] && mt[ret_arch] == int'(ret_tag)) mv[ret_arch] = 1'b0;
      for (int j = 0; j < L; j++)
        if (grp_valid[j]) begin mv[grp_dst[j]] = 1'b1; mt[grp_dst[j]] = int'(grp_tag[j]); end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    grp_valid = '0; ret_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic set_lane(input int k, input int d, input int sa, input int sb, input int t);
    grp_valid[k] = 1'b1;
    grp_dst[k] = AW'(d); grp_src_a[k] = AW'(sa); grp_src_b[k] = AW'(sb); grp_tag[k] = TW'(t);
  endtask

  initial begin
    #(CLK_P*150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int alloc;
    for (int a = 0; a < NR; a++) begin mv[a] = 1'b0; mt[a] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every register reads from the architectural file after reset
    for (int k = 0; k < L; k++) set_lane(k, 0, 2*k, 2*k+1, k);
    #1;
    for (int k = 0; k < L; k++) if (k > 0) grp_valid[k] = 1'b0;
    grp_dst[0] = 3'd7; grp_src_a[0] = 3'd0; grp_src_b[0] = 3'd1;
    #1;
    chk("R1 lane0 srcA inflight", int'(src_a_inflight[0]), 0);
    chk("R1 lane0 srcB tag", int'(src_b_tag[0]), 0);
    grp_valid = '1;
    for (int k = 0; k < L; k++) begin grp_dst[k] = 3'd7; grp_tag[k] = TW'(k); end
    grp_dst[L-1] = 3'd7;
    #1;
    for (int k = 0; k < L; k++) begin
      grp_src_a[k] = AW'(k); grp_src_b[k] = AW'(k+4);
      grp_dst[k] = 3'd7;
    end
    grp_valid = 4'b0001;
    #1;
    check_all("R1,R3");
    idle(); @(negedge clk);

    // R10: the worked example, same group
    set_lane(0, 1, 0, 0, 19); set_lane(1, 2, 0, 0, 23);
    tick(); idle();
    set_lane(0, 0, 1, 0, 37); set_lane(1, 0, 2, 0, 38);
    #1;
    chk("R10 op1 srcA inflight", int'(src_a_inflight[0]), 1);
    chk("R10 op1 srcA tag", int'(src_a_tag[0]), 19);
    chk("R10 op1 srcB inflight", int'(src_b_inflight[0]), 0);
    chk("R10 op2 srcA tag", int'(src_a_tag[1]), 23);
    chk("R10 op2 srcB inflight", int'(src_b_inflight[1]), 1);
    chk("R10 op2 srcB tag", int'(src_b_tag[1]), 37);
    tick(); idle();
    // R5: the youngest writer (38) owns r0
    set_lane(0, 5, 0, 3, 1);
    #1;
    chk("R5 r0 holds youngest", int'(src_a_tag[0]), 38);
    chk("R3 r3 unmapped", int'(src_b_inflight[0]), 0);
    idle();
    // R10: successive cycles after flushing r0
    flush = 1'b1; tick(); idle();
    set_lane(0, 1, 0, 0, 19); set_lane(1, 2, 0, 0, 23); tick(); idle();
    set_lane(0, 0, 1, 0, 37); #1;
    chk("R10 seq op1 srcA tag", int'(src_a_tag[0]), 19);
    chk("R10 seq op1 srcB inflight", int'(src_b_inflight[0]), 0);
    tick(); idle();
    set_lane(0, 0, 2, 0, 38); #1;
    chk("R10 seq op2 srcA tag", int'(src_a_tag[0]), 23);
    chk("R10 seq op2 srcB tag", int'(src_b_tag[0]), 37);
    tick(); idle();

    // R6: stale retire (37) keeps r0 at 38; matching retire (38) clears
    ret_valid = 1'b1; ret_arch = 3'd0; ret_tag = 6'd37; tick(); idle();
    set_lane(0, 7, 0, 0, 2); #1;
    chk("R6 stale retire keeps", int'(src_a_tag[0]), 38);
    idle();
    ret_valid = 1'b1; ret_arch = 3'd0; ret_tag = 6'd38; tick(); idle();
    set_lane(0, 6, 0, 0, 3); #1;
    chk("R6 matching retire clears", int'(src_a_inflight[0]), 0);
    idle();

    // R7: rename of r3 in the retire cycle of r3's current tag wins
    set_lane(0, 3, 0, 0, 5); tick(); idle();
    ret_valid = 1'b1; ret_arch = 3'd3; ret_tag = 6'd5; set_lane(2, 3, 0, 0, 6);
    tick(); idle();
    set_lane(0, 4, 3, 3, 7); #1;
    chk("R7 rename beats retire inflight", int'(src_a_inflight[0]), 1);
    chk("R7 rename beats retire tag", int'(src_a_tag[0]), 6);
    idle();

    // R4: older in-group writer beats table; youngest of two wins
    set_lane(0, 6, 0, 0, 2); set_lane(1, 1, 6, 6, 8); set_lane(2, 6, 0, 0, 3);
    set_lane(3, 1, 6, 3, 9);
    #1;
    chk("R4 lane1 bypass from lane0", int'(src_a_tag[1]), 2);
    chk("R4 lane3 youngest bypass", int'(src_a_tag[3]), 3);
    check_all("R4");
    tick(); idle();

    // R9: idle lane 1 writes r5 but must not bypass nor write
    set_lane(1, 5, 5, 5, 11); grp_valid[1] = 1'b0; set_lane(2, 2, 5, 5, 12);
    #1;
    chk("R9 idle lane quiet", int'(src_a_inflight[1]), 0);
    chk("R9 no bypass from idle lane", int'(src_a_inflight[2]), 0);
    tick(); idle();
    set_lane(0, 2, 5, 5, 13); #1;
    chk("R9 idle lane did not write", int'(src_a_inflight[0]), 0);
    idle();

    // R8: flush beats a same-cycle rename; every register empties
    set_lane(0, 4, 0, 0, 9); set_lane(1, 0, 0, 0, 10); flush = 1'b1;
    ret_valid = 1'b1; ret_arch = 3'd6; ret_tag = 6'd3;
    tick(); idle();
    for (int a = 0; a < NR; a += 2) begin
      set_lane(0, 7, a, a+1, 1); #1;
      chk("R8 flushed srcA", int'(src_a_inflight[0]), 0);
      chk("R8 flushed srcB", int'(src_b_inflight[0]), 0);
    end
    idle(); @(negedge clk);

    // R2,R3,R4,R5,R6,R7,R8,R9: long pseudo-random sweep against the model
    lfsr = 16'hACE1; alloc = 0;
    for (int c = 0; c < 4000; c++) begin
      for (int k = 0; k < L; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        grp_valid[k] = lfsr[0] | lfsr[5];
        grp_dst[k] = lfsr[3:1]; grp_src_a[k] = lfsr[8:6]; grp_src_b[k] = lfsr[11:9];
        grp_tag[k] = TW'(alloc); alloc = (alloc + 1) % ROB;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ret_valid = lfsr[0];
      ret_arch = lfsr[3:1];
      ret_tag = lfsr[4] ? TW'(mt[lfsr[3:1]]) : TW'(int'(lfsr[10:5]) % ROB);
      flush = (lfsr[15:11] == 5'd0);
      #1;
      check_all("R2,R3,R4,R5,R6,R7,R8,R9 sweep");
      tick();
    end
    idle(); @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule